// File: doc/BRIEF.md
# Dual-Mode 8-bit Interval Timer

This block is an 8-bit up-counter with two operating personalities chosen by one bit of a small control register. In interval mode the counter advances on one of eight taps of a free-running system-clock divider, so software gets a periodic overflow whose period is 256 times the chosen tap ratio. In time-base mode the counter advances on a divided version of a slow, asynchronous clock. That clock is brought into the system domain through a synchronizer and an edge detector, then divided by one of four ratios. In this mode a control bit acts as a clear strobe for both the counter and the slow divider.

Every counter overflow sets a sticky flag, and an interrupt request is raised while the flag and its enable are both set. A power-state input gates the block. In the run state everything operates. In the watch state only the time-base function keeps counting. In the standby state nothing counts. In every state other than run, the register contents are frozen.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the counter reads 0x00, the control field reads 0 (interval mode, tap 0), the overflow flag and interrupt enable read 0, and the interrupt request is low.
- R2: In interval mode, control bits 2..0 (sel) pick the count rate. The counter advances once every N system clocks, where sel 0..7 gives N = 8192, 4096, 2048, 512, 256, 128, 32, 2.
- R3: A count event at 0xFF wraps the counter to 0x00 and sets the overflow flag, so overflows are 256 count events apart.
- R4: The interrupt request is high exactly while the overflow flag and the interrupt enable are both 1.
- R5: The status register is at address 1, with bit 0 the flag and bit 1 the enable. Writing bit 0 as 0 clears the flag. Writing it as 1 leaves the flag unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R6: In time-base mode (control bit 3 = 1), control bits 1..0 pick the ratio. The counter advances once per N rising edges of the slow clock, where values 0..3 give N = 128, 64, 32, 4.
- R7: A write to the control register (address 0) with bits 3 and 2 both 1 clears the counter and the slow divider in the next cycle. In interval mode, bit 2 is only a tap-select bit and leaves the counter alone.
- R8: The slow clock is resynchronized into the system domain. Each rising slow-clock edge yields exactly one count step, however long the slow clock stays high.
- R9: The power input uses 00 for run, 01 for watch, and 10 or 11 for standby. Interval counting runs only in run. Time-base counting runs in run and watch. Nothing counts in standby.
- R10: Outside the run state, register writes are ignored and the control field and enable hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Asynchronous slow clock, sampled as data |
| pwr_state | input | 2 | Power state: 00 run, 01 watch, 1x standby |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = status register |
| wr_data | input | 4 | Write data |
| cnt_o | output | 8 | Current counter value |
| ctrl_o | output | 4 | Control field: bit 3 mode, bits 2..0 select |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_en_o | output | 1 | Interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to produce from the ports is a flag-clearing write that lands on the very cycle of an overflow. The stimulus uses the divide-by-2 tap, whose count steps fall on alternate clocks. The bench watches for the first cycle the counter shows 0xFF and so learns which edge carried that step. It then places the clearing write exactly two edges later, on the wrapping step. The time-base ratios are checked by clearing the slow divider first, so the bench knows its phase. It then feeds N-1 slow edges, during which the counter must not move, followed by the Nth edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam logic [1:0] PWR_RUN   = 2'b00;
  localparam logic [1:0] PWR_WATCH = 2'b01;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  // log2 of the system divider ratio for each interval-mode select value
  function automatic int unsigned sys_tap_bits(logic [2:0] sel);
    case (sel)
      3'd0:    return 13;
      3'd1:    return 12;
      3'd2:    return 11;
      3'd3:    return 9;
      3'd4:    return 8;
      3'd5:    return 7;
      3'd6:    return 5;
      default: return 1;
    endcase
  endfunction

  // log2 of the slow divider ratio for each time-base select value
  function automatic int unsigned slow_tap_bits(logic [1:0] sel);
    case (sel)
      2'd0:    return 7;
      2'd1:    return 6;
      2'd2:    return 5;
      default: return 2;
    endcase
  endfunction

  // true when the low 'bits' bits of a divider are all ones (carry ready)
  function automatic logic tap_ready(logic [15:0] val, int unsigned bits);
    logic [15:0] mask;
    mask = (bits >= 16) ? 16'hFFFF : ((16'd1 << bits) - 16'd1);
    return (val & mask) == mask;
  endfunction

  // overflow set wins over a software clear
  function automatic logic next_flag(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/tmr_sys_prescaler.sv
module tmr_sys_prescaler #(
  parameter int PSC_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import tmr_pkg::*;

  logic [PSC_W-1:0] psc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   psc_q <= '0;
    else if (run) psc_q <= psc_q + 1'b1;
  end

  assign tick = run && tap_ready(16'(psc_q), sys_tap_bits(sel));

endmodule

// File: rtl/tmr_slow_source.sv
module tmr_slow_source #(
  parameter int PSC_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_clk,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       edge_o,
  output logic       tick_o
);
  import tmr_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [PSC_W-1:0]       psc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], slow_clk};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign edge_o = sync_q[SYNC_STAGES-1] && !prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              psc_q <= '0;
    else if (clr)            psc_q <= '0;
    else if (edge_o && run)  psc_q <= psc_q + 1'b1;
  end

  assign tick_o = edge_o && run && tap_ready(16'(psc_q), slow_tap_bits(sel));

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             flag,
  output logic             ovf
);
  import tmr_pkg::*;

  assign ovf = evt && !clr && (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (clr)      cnt <= '0;
      else if (evt) cnt <= cnt + 1'b1;
      flag <= next_flag(flag, ovf, flag_clr);
    end
  end

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
  parameter int CNT_W       = 8,
  parameter int SYS_PSC_W   = 13,
  parameter int SLOW_PSC_W  = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic [1:0]       pwr_state,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [3:0]       wr_data,
  output logic [CNT_W-1:0] cnt_o,
  output logic [3:0]       ctrl_o,
  output logic             ovf_flag_o,
  output logic             irq_en_o,
  output logic             irq_o
);
  import tmr_pkg::*;

  logic [3:0] ctrl_q;
  logic       irq_en_q;
  logic       wr_ok, ctrl_wr, stat_wr;
  logic       iv_run, tb_run, mode_tb;
  logic       sys_tick, slow_edge, slow_tick;
  logic       cnt_evt, ovf_evt, clr_evt, flag_clr;

  assign iv_run  = (pwr_state == PWR_RUN);
  assign tb_run  = (pwr_state == PWR_RUN) || (pwr_state == PWR_WATCH);
  assign mode_tb = ctrl_q[3];

  assign wr_ok    = wr_en && iv_run;
  assign ctrl_wr  = wr_ok && (wr_addr == ADDR_CTRL);
  assign stat_wr  = wr_ok && (wr_addr == ADDR_STAT);
  assign clr_evt  = ctrl_wr && wr_data[3] && wr_data[2];
  assign flag_clr = stat_wr && !wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      irq_en_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q   <= wr_data;
      if (stat_wr) irq_en_q <= wr_data[1];
    end
  end

  tmr_sys_prescaler #(.PSC_W(SYS_PSC_W)) u_sys_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (iv_run),
    .sel  (ctrl_q[2:0]),
    .tick (sys_tick)
  );

  tmr_slow_source #(.PSC_W(SLOW_PSC_W), .SYNC_STAGES(SYNC_STAGES)) u_slow (
    .clk     (clk),
    .rst_n   (rst_n),
    .slow_clk(slow_clk),
    .run     (tb_run),
    .clr     (clr_evt),
    .sel     (ctrl_q[1:0]),
    .edge_o  (slow_edge),
    .tick_o  (slow_tick)
  );

  assign cnt_evt = mode_tb ? slow_tick : sys_tick;

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (cnt_evt),
    .clr     (clr_evt),
    .flag_clr(flag_clr),
    .cnt     (cnt_o),
    .flag    (ovf_flag_o),
    .ovf     (ovf_evt)
  );

  assign ctrl_o   = ctrl_q;
  assign irq_en_o = irq_en_q;
  assign irq_o    = ovf_flag_o && irq_en_q;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pwr,
  input logic             mode,
  input logic [CNT_W-1:0] cnt,
  input logic [3:0]       ctrl,
  input logic             flag,
  input logic             irq_en,
  input logic             irq,
  input logic             cnt_evt,
  input logic             ovf_evt,
  input logic             clr_evt,
  input logic             flag_clr,
  input logic             slow_edge
);

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (cnt == '0 && ctrl == '0 && !flag && !irq_en)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && !clr_evt && !(&cnt)) |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R2

  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && !clr_evt && (&cnt)) |=> (cnt == '0 && flag)); // R3

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && irq_en) |=> irq); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R5

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ovf_evt) |=> !flag); // R5

  AST_CLEAR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> cnt == '0); // R7

  AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    slow_edge |=> !slow_edge); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_evt && !clr_evt) |=> $stable(cnt)); // R9

  AST_INTERVAL_LOWPWR: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr != 2'b00 && !mode) |-> !cnt_evt); // R9

  AST_STANDBY_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    pwr[1] |-> !cnt_evt); // R9

  AST_REGS_RETAINED: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr != 2'b00) |=> ($stable(ctrl) && $stable(irq_en))); // R10

endmodule

bind dual_mode_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr      (pwr_state),
  .mode     (ctrl_q[3]),
  .cnt      (cnt_o),
  .ctrl     (ctrl_o),
  .flag     (ovf_flag_o),
  .irq_en   (irq_en_o),
  .irq      (irq_o),
  .cnt_evt  (cnt_evt),
  .ovf_evt  (ovf_evt),
  .clr_evt  (clr_evt),
  .flag_clr (flag_clr),
  .slow_edge(slow_edge)
);

// File: tb/tb_dual_mode_timer.sv
module tb_dual_mode_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slow_clk = 1'b0;
  logic [1:0] pwr_state = 2'b00;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [3:0] wr_data = 4'h0;
  logic [7:0] cnt_o;
  logic [3:0] ctrl_o;
  logic       ovf_flag_o, irq_en_o, irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_timer dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pwr_state(pwr_state),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_o(cnt_o), .ctrl_o(ctrl_o), .ovf_flag_o(ovf_flag_o),
    .irq_en_o(irq_en_o), .irq_o(irq_o)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic slow_pulse(int high_cycles);
    slow_clk = 1'b1;
    repeat (high_cycles) @(negedge clk);
    slow_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cnt_o == 8'h00, "R1", "counter", cnt_o, 0);
    chk(ctrl_o == 4'h0, "R1", "control", ctrl_o, 0);
    chk(!ovf_flag_o && !irq_en_o, "R1", "flag/enable", {ovf_flag_o, irq_en_o}, 0);
    chk(!irq_o, "R1", "irq", irq_o, 0);
  endtask

  task automatic t_interval_taps;
    int sels[4]   = '{7, 6, 5, 3};
    int ratios[4] = '{2, 32, 128, 512};
    for (int i = 0; i < 4; i++) begin
      logic [7:0] c0;
      logic [7:0] c1;
      wr(1'b0, 4'(sels[i]));
      repeat (3) @(negedge clk);
      c0 = cnt_o;
      repeat (ratios[i] * 4) @(negedge clk);
      c1 = cnt_o;
      chk(8'(c1 - c0) == 8'd4, "R2", $sformatf("steps over 4 periods sel %0d", sels[i]),
          8'(c1 - c0), 4);
    end
  endtask

  task automatic t_overflow;
    int n;
    wr(1'b0, 4'h7);
    wr(1'b1, 4'h0);
    while (cnt_o == 8'hFF) @(negedge clk);
    while (cnt_o != 8'hFF) @(negedge clk);
    while (cnt_o != 8'h00) @(negedge clk);
    chk(ovf_flag_o, "R3", "flag after wrap", ovf_flag_o, 1);
    n = 0;
    while (cnt_o == 8'h00) begin @(negedge clk); n++; end
    while (cnt_o != 8'h00) begin @(negedge clk); n++; end
    chk(n == 512, "R3", "cycles between wraps at ratio 2", n, 512);
  endtask

  task automatic t_irq_and_flag;
    wr(1'b1, 4'b0011);
    chk(ovf_flag_o, "R5", "flag kept by writing 1", ovf_flag_o, 1);
    chk(irq_o, "R4", "irq with flag and enable", irq_o, 1);
    wr(1'b1, 4'b0001);
    chk(!irq_o && ovf_flag_o, "R4", "irq low with enable off", irq_o, 0);
    wr(1'b1, 4'b0000);
    chk(!ovf_flag_o, "R5", "flag cleared by writing 0", ovf_flag_o, 0);
  endtask

  task automatic t_clear_race;
    while (cnt_o == 8'hFF) @(negedge clk);
    while (cnt_o != 8'hFF) @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b1; wr_data = 4'b0000;
    @(negedge clk);
    wr_en = 1'b0;
    chk(cnt_o == 8'h00, "R3", "wrap on race edge", cnt_o, 0);
    chk(ovf_flag_o, "R5", "overflow beats clear", ovf_flag_o, 1);
  endtask

  task automatic t_interval_bit2;
    logic [7:0] prev;
    repeat (10) @(negedge clk);
    prev = cnt_o;
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 4'b0100;
    @(negedge clk);
    wr_en = 1'b0;
    chk(cnt_o != 8'h00 && (cnt_o == prev || cnt_o == 8'(prev + 1)), "R7",
        "interval bit2 keeps counter", cnt_o, prev);
    chk(ctrl_o == 4'b0100, "R7", "tap select stored", ctrl_o, 4);
  endtask

  task automatic t_watch_interval;
    logic [7:0] prev;
    @(negedge clk);
    pwr_state = 2'b01;
    prev = cnt_o;
    repeat (600) @(negedge clk);
    chk(cnt_o == prev, "R9", "interval halted in watch", cnt_o, prev);
    wr(1'b0, 4'b1000);
    chk(ctrl_o == 4'b0100, "R10", "control write ignored in watch", ctrl_o, 4);
    pwr_state = 2'b00;
  endtask

  task automatic t_timebase;
    int divs[4] = '{128, 64, 32, 4};
    wr(1'b0, 4'b1011);
    wr(1'b0, 4'b1111);
    chk(cnt_o == 8'h00, "R7", "clear strobe", cnt_o, 0);
    for (int s = 0; s < 4; s++) begin
      wr(1'b0, 4'(4'b1100 | s));
      chk(cnt_o == 8'h00, "R7", "clear strobe per ratio", cnt_o, 0);
      repeat (divs[s] - 1) slow_pulse(3);
      chk(cnt_o == 8'h00, "R6", $sformatf("no step before edge %0d", divs[s]), cnt_o, 0);
      slow_pulse(3);
      chk(cnt_o == 8'h01, "R6", $sformatf("step at edge %0d", divs[s]), cnt_o, 1);
    end
    repeat (4) slow_pulse(30);
    chk(cnt_o == 8'h02, "R8", "long-high edges count once each", cnt_o, 2);
  endtask

  task automatic t_power_timebase;
    logic [7:0] prev;
    pwr_state = 2'b01;
    repeat (4) slow_pulse(3);
    chk(cnt_o == 8'h03, "R9", "time base counts in watch", cnt_o, 3);
    pwr_state = 2'b10;
    prev = cnt_o;
    repeat (8) slow_pulse(3);
    chk(cnt_o == prev, "R9", "standby halts time base", cnt_o, prev);
    wr(1'b1, 4'b0010);
    chk(!irq_en_o, "R10", "status write ignored in standby", irq_en_o, 0);
    pwr_state = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_interval_taps();
    t_overflow();
    t_irq_and_flag();
    t_clear_race();
    t_interval_bit2();
    t_watch_interval();
    t_timebase();
    t_power_timebase();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule